// File: doc/BRIEF.md
# Registered Integer ALU with Decoded Controls

This block is the execute-stage arithmetic and logic unit of a small RISC pipeline. It takes two 32-bit operands and a set of control fields that an upstream decoder has already produced. It returns one 32-bit result and three comparison flags. The block does no opcode decoding of its own.

Inside are four paths:
- an adder whose second operand passes through a four-way conditioning mux, with the carry-in taken from that mux's select;
- a bitwise logic unit with an optional output complement;
- a logarithmic barrel shifter;
- a set-on-less-than path.

A priority mux chooses among them, and result and flags are registered once, so they appear one clock after the inputs.

Conditioning the second operand lets one adder cover four instructions:
- addition, by passing B;
- subtraction, by inverting B with carry-in set;
- load-upper-immediate, by shifting B up half a word;
- increment, by forcing B to zero with carry-in set.

A NOR is formed by setting the complement enable on the OR path. The shift amount is an input, so the decoder can take it from the instruction or from the low bits of operand A.

Top module: `ialu_top`

## Requirements
- R1: While `rst` is high on a rising clock edge, `result`, `flag_a_neg`, `flag_eq` and `flag_lt` are cleared to 0 at that edge. Otherwise every output shows, one rising edge later, the function of the inputs sampled at that edge.
- R2: With `en_arith`=1 and `opnd_sel`=2'b00, `result` is `opa + opb` modulo 2^32. Overflow is not reported and the sum simply wraps.
- R3: With `en_arith`=1 and `opnd_sel`=2'b01, the adder sees the bitwise inverse of `opb` with a carry-in of 1, so `result` is `opa - opb` modulo 2^32.
- R4: With `en_arith`=1 and `opnd_sel`=2'b10, `result` is `opa + (opb << 16)` with a carry-in of 0. With `opa`=0 this places the low half of `opb` in the upper half of the result.
- R5: With `en_arith`=1 and `opnd_sel`=2'b11, the second adder operand is zero and the carry-in is 1, so `result` is `opa + 1`.
- R6: With `en_logic`=1, `logic_sel` picks 2'b00 AND, 2'b01 OR, 2'b10 XOR or 2'b11 all zeros. When `logic_inv`=1 that value is complemented, so OR with `logic_inv`=1 gives NOR.
- R7: With no group enable set, `result` is the shifter output: `opa` shifted by `shamt` (0 to 31). `shift_sel` bit 1 picks right (1) or left (0). Bit 0 picks arithmetic fill for right shifts only, so 2'b00 and 2'b01 are logical left, 2'b10 is logical right and 2'b11 is arithmetic right.
- R8: With `en_slt`=1, `result` is 32'd1 when `opa` is below `opb` and 32'd0 otherwise. The comparison is two's-complement signed when `cmp_unsigned`=0 and unsigned when it is 1.
- R9: On every cycle, whatever the enables, `flag_a_neg` is bit 31 of `opa` and `flag_eq` is `opa == opb`. `flag_lt` is `opa < opb`, signed or unsigned as set by `cmp_unsigned`.
- R10: When several enables are set, `en_slt` wins over `en_logic`, `en_logic` wins over `en_arith`, and the shifter is used only when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| opnd_sel | input | 2 | Second adder operand: 00 B, 01 ~B, 10 B<<16, 11 zero; bit 0 is the carry-in |
| logic_sel | input | 2 | 00 AND, 01 OR, 10 XOR, 11 zero |
| logic_inv | input | 1 | Complement the logic unit output |
| shift_sel | input | 2 | 00/01 left logical, 10 right logical, 11 right arithmetic |
| shamt | input | 5 | Shift distance |
| cmp_unsigned | input | 1 | Unsigned less-than compare when 1 |
| en_slt | input | 1 | Select set-on-less-than result |
| en_logic | input | 1 | Select logic unit result |
| en_arith | input | 1 | Select adder result |
| result | output | 32 | Registered result |
| flag_a_neg | output | 1 | Registered: A below zero |
| flag_eq | output | 1 | Registered: A equals B |
| flag_lt | output | 1 | Registered: A below B |

## Verification
The block has no state apart from its output register. A fault in any datapath therefore appears on `result` or a flag at the first edge after the operands that excite it. The bench issues operand pairs that fall on either side of each corner:
- sign-bit crossings, where the signed and unsigned compares disagree;
- equal operands;
- wrapping sums;
- shift distances 0 and 31;
- negative values shifted right.

It also sets several enables at once so that a wrong priority order shows up as the result of the wrong group.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  // Second adder operand conditioning codes; bit 0 doubles as carry-in.
  typedef enum logic [1:0] {
    OPND_PASS  = 2'b00,
    OPND_INV   = 2'b01,
    OPND_HIGH  = 2'b10,
    OPND_ZERO  = 2'b11
  } opnd_sel_e;

  typedef enum logic [1:0] {
    LOG_AND  = 2'b00,
    LOG_OR   = 2'b01,
    LOG_XOR  = 2'b10,
    LOG_NONE = 2'b11
  } logic_sel_e;

  typedef enum logic [1:0] {
    RES_SHIFT = 2'b00,
    RES_ARITH = 2'b01,
    RES_LOGIC = 2'b10,
    RES_SLT   = 2'b11
  } res_src_e;

  typedef struct packed {
    logic a_neg;
    logic eq;
    logic lt;
  } ialu_flags_t;

endpackage

// File: rtl/ialu_adder.sv
module ialu_adder
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  opnd_sel_e         sel,
  output logic [DATA_W-1:0] sum
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] opb_cond;
  logic              cin;

  always_comb begin
    unique case (sel)
      OPND_PASS: opb_cond = opb;
      OPND_INV:  opb_cond = ~opb;
      OPND_HIGH: opb_cond = {opb[DATA_W-HALF_W-1:0], {HALF_W{1'b0}}};
      default:   opb_cond = '0;
    endcase
  end

  assign cin = sel[0];
  assign sum = opa + opb_cond + {{(DATA_W-1){1'b0}}, cin};

endmodule

// File: rtl/ialu_compare.sv
module ialu_compare
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              is_unsigned,
  output ialu_flags_t       flags
);
  logic [DATA_W:0] diff;
  logic            borrow;
  logic            ovf;
  logic            lt_signed;

  // Dedicated subtractor so flags do not depend on the conditioning mux.
  assign diff      = {1'b0, opa} + {1'b0, ~opb} + {{DATA_W{1'b0}}, 1'b1};
  assign borrow    = ~diff[DATA_W];
  assign ovf       = (opa[DATA_W-1] != opb[DATA_W-1]) &&
                     (diff[DATA_W-1] != opa[DATA_W-1]);
  assign lt_signed = diff[DATA_W-1] ^ ovf;

  assign flags.a_neg = opa[DATA_W-1];
  assign flags.eq    = (diff[DATA_W-1:0] == '0);
  assign flags.lt    = is_unsigned ? borrow : lt_signed;

endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic_sel_e        sel,
  input  logic              invert,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (sel)
      LOG_AND: raw = opa & opb;
      LOG_OR:  raw = opa | opb;
      LOG_XOR: raw = opa ^ opb;
      default: raw = '0;
    endcase
  end

  assign y = invert ? ~raw : raw;

endmodule

// File: rtl/ialu_shifter.sv
module ialu_shifter #(
  parameter int DATA_W = 32,
  parameter int SHW    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SHW-1:0]    amt,
  input  logic              right,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [SHW+1];
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic              fill;

  // Left shifts reuse the right-shift network on bit-reversed data.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign rev_in[i]  = din[DATA_W-1-i];
      assign rev_out[i] = stage[SHW][DATA_W-1-i];
    end
  endgenerate

  assign fill     = right & arith & din[DATA_W-1];
  assign stage[0] = right ? din : rev_in;

  generate
    for (genvar s = 0; s < SHW; s++) begin : g_stage
      localparam int DIST = 1 << s;
      assign stage[s+1] = amt[s] ?
        {{DIST{fill}}, stage[s][DATA_W-1:DIST]} : stage[s];
    end
  endgenerate

  assign dout = right ? stage[SHW] : rev_out;

endmodule

// File: rtl/ialu_top.sv
module ialu_top
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        opnd_sel,
  input  logic [1:0]        logic_sel,
  input  logic              logic_inv,
  input  logic [1:0]        shift_sel,
  input  logic [SHW-1:0]    shamt,
  input  logic              cmp_unsigned,
  input  logic              en_slt,
  input  logic              en_logic,
  input  logic              en_arith,
  output logic [DATA_W-1:0] result,
  output logic              flag_a_neg,
  output logic              flag_eq,
  output logic              flag_lt
);
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] log_w;
  logic [DATA_W-1:0] shf_w;
  logic [DATA_W-1:0] slt_w;
  logic [DATA_W-1:0] res_d;
  ialu_flags_t       flg_w;
  res_src_e          src;

  ialu_adder #(.DATA_W(DATA_W)) u_add (
    .opa (opa),
    .opb (opb),
    .sel (opnd_sel_e'(opnd_sel)),
    .sum (sum_w)
  );

  ialu_compare #(.DATA_W(DATA_W)) u_cmp (
    .opa         (opa),
    .opb         (opb),
    .is_unsigned (cmp_unsigned),
    .flags       (flg_w)
  );

  ialu_logic #(.DATA_W(DATA_W)) u_log (
    .opa    (opa),
    .opb    (opb),
    .sel    (logic_sel_e'(logic_sel)),
    .invert (logic_inv),
    .y      (log_w)
  );

  ialu_shifter #(.DATA_W(DATA_W), .SHW(SHW)) u_shf (
    .din   (opa),
    .amt   (shamt),
    .right (shift_sel[1]),
    .arith (shift_sel[0]),
    .dout  (shf_w)
  );

  assign slt_w = {{(DATA_W-1){1'b0}}, flg_w.lt};

  always_comb begin
    if (en_slt)        src = RES_SLT;
    else if (en_logic) src = RES_LOGIC;
    else if (en_arith) src = RES_ARITH;
    else               src = RES_SHIFT;
  end

  always_comb begin
    unique case (src)
      RES_SLT:   res_d = slt_w;
      RES_LOGIC: res_d = log_w;
      RES_ARITH: res_d = sum_w;
      default:   res_d = shf_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      flag_a_neg <= 1'b0;
      flag_eq    <= 1'b0;
      flag_lt    <= 1'b0;
    end else begin
      result     <= res_d;
      flag_a_neg <= flg_w.a_neg;
      flag_eq    <= flg_w.eq;
      flag_lt    <= flg_w.lt;
    end
  end

endmodule

// File: rtl/ialu_chk.sv
module ialu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              cmp_unsigned,
  input logic              en_slt,
  input logic [DATA_W-1:0] result,
  input logic              flag_a_neg,
  input logic              flag_eq,
  input logic              flag_lt
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !flag_a_neg && !flag_eq && !flag_lt));

  // R9
  eq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (flag_eq == ($past(opa) == $past(opb))));

  // R9
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (flag_a_neg == $past(opa[DATA_W-1])));

  // R9
  ult_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(cmp_unsigned)) |-> (flag_lt == ($past(opa) < $past(opb))));

  // R8
  slt_result_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(en_slt)) |-> (result == {{(DATA_W-1){1'b0}}, flag_lt}));

endmodule

bind ialu_top ialu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .opa          (opa),
  .opb          (opb),
  .cmp_unsigned (cmp_unsigned),
  .en_slt       (en_slt),
  .result       (result),
  .flag_a_neg   (flag_a_neg),
  .flag_eq      (flag_eq),
  .flag_lt      (flag_lt)
);

// File: tb/sim_ialu_top.sv
`timescale 1ns/1ps
module sim_ialu_top;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  opa = '0, opb = '0;
  logic [1:0]    opnd_sel = '0, logic_sel = '0, shift_sel = '0;
  logic          logic_inv = 1'b0, cmp_unsigned = 1'b0;
  logic [4:0]    shamt = '0;
  logic          en_slt = 1'b0, en_logic = 1'b0, en_arith = 1'b0;
  logic [W-1:0]  result;
  logic          flag_a_neg, flag_eq, flag_lt;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    string        tag;
    logic [W-1:0] res;
    logic         neg;
    logic         eq;
    logic         lt;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  ialu_top u0 (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb),
    .opnd_sel(opnd_sel), .logic_sel(logic_sel), .logic_inv(logic_inv),
    .shift_sel(shift_sel), .shamt(shamt), .cmp_unsigned(cmp_unsigned),
    .en_slt(en_slt), .en_logic(en_logic), .en_arith(en_arith),
    .result(result), .flag_a_neg(flag_a_neg), .flag_eq(flag_eq),
    .flag_lt(flag_lt)
  );

  // Driver: sets inputs at the falling edge and records the expectation.
  task automatic apply(input string tag, input logic [1:0] os,
                       input logic [1:0] ls, input logic li,
                       input logic [1:0] ss, input logic [4:0] sh,
                       input logic un, input logic es, input logic el,
                       input logic ea, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] exp_res);
    exp_t e;
    @(negedge clk);
    opnd_sel = os; logic_sel = ls; logic_inv = li; shift_sel = ss;
    shamt = sh; cmp_unsigned = un; en_slt = es; en_logic = el;
    en_arith = ea; opa = a; opb = b;
    e.tag = tag;
    e.res = exp_res;
    e.neg = a[W-1];
    e.eq  = (a == b);
    e.lt  = un ? (a < b) : ($signed(a) < $signed(b));
    sb.push_back(e);
  endtask

  // Monitor: compares one item after each rising edge.
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (result !== e.res) begin
        n_fail++;
        $display("FAIL %s result: got %h expected %h", e.tag, result, e.res);
      end
      n_chk++;
      if ({flag_a_neg, flag_eq, flag_lt} !== {e.neg, e.eq, e.lt}) begin
        n_fail++;
        $display("FAIL %s flags (R9): got %b expected %b", e.tag,
                 {flag_a_neg, flag_eq, flag_lt}, {e.neg, e.eq, e.lt});
      end
    end
  end

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    opa = 32'hFFFF_FFFF; opb = 32'hFFFF_FFFF; en_arith = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;  // R1 reset clears outputs
    if ({result, flag_a_neg, flag_eq, flag_lt} !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: got %h/%b expected 0/000", result,
               {flag_a_neg, flag_eq, flag_lt});
    end
    @(negedge clk);
    rst = 1'b0;

    // R2 addition and wrap
    apply("R2 add",  2'b00, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'd1234, 32'd4321, 32'd5555);
    apply("R2 wrap", 2'b00, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000);
    apply("R2 carry", 2'b00, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001);
    // R3 subtraction
    apply("R3 sub",  2'b01, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'd10, 32'd3, 32'd7);
    apply("R3 sub neg", 2'b01, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'd3, 32'd10, 32'd3 - 32'd10);
    apply("R3 sub eq", 2'b01, 2'b00, 0, 2'b00, 5'd0, 1, 0, 0, 1,
          32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd0);
    // R4 upper half
    apply("R4 lui",  2'b10, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'd0, 32'h0000_ABCD, 32'hABCD_0000);
    apply("R4 add hi", 2'b10, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'h0000_0011, 32'h1234_5678, 32'h5678_0011);
    // R5 zero operand with carry-in
    apply("R5 inc",  2'b11, 2'b00, 0, 2'b00, 5'd0, 0, 0, 0, 1,
          32'h0000_00FF, 32'h5555_5555, 32'h0000_0100);
    // R6 logic
    apply("R6 and",  2'b00, 2'b00, 0, 2'b00, 5'd0, 0, 0, 1, 0,
          32'hF0F0_1234, 32'hFF00_FF0F, 32'hF000_1204);
    apply("R6 or",   2'b00, 2'b01, 0, 2'b00, 5'd0, 0, 0, 1, 0,
          32'hF0F0_0000, 32'h0F00_000F, 32'hFFF0_000F);
    apply("R6 xor",  2'b00, 2'b10, 0, 2'b00, 5'd0, 0, 0, 1, 0,
          32'hFFFF_0000, 32'hF0F0_F0F0, 32'h0F0F_F0F0);
    apply("R6 nor",  2'b00, 2'b01, 1, 2'b00, 5'd0, 0, 0, 1, 0,
          32'hF0F0_0000, 32'h0F00_000F, 32'h000F_FFF0);
    apply("R6 none", 2'b00, 2'b11, 0, 2'b00, 5'd0, 0, 0, 1, 0,
          32'h1234_5678, 32'h8765_4321, 32'd0);
    // R7 shifts
    apply("R7 sll",  2'b00, 2'b00, 0, 2'b00, 5'd4, 0, 0, 0, 0,
          32'h8123_4567, 32'd0, 32'h1234_5670);
    apply("R7 sll01", 2'b00, 2'b00, 0, 2'b01, 5'd31, 0, 0, 0, 0,
          32'h0000_0003, 32'd0, 32'h8000_0000);
    apply("R7 srl",  2'b00, 2'b00, 0, 2'b10, 5'd8, 0, 0, 0, 0,
          32'h8123_4567, 32'd0, 32'h0081_2345);
    apply("R7 sra",  2'b00, 2'b00, 0, 2'b11, 5'd8, 0, 0, 0, 0,
          32'h8123_4567, 32'd0, 32'hFF81_2345);
    apply("R7 sra31", 2'b00, 2'b00, 0, 2'b11, 5'd31, 0, 0, 0, 0,
          32'h8000_0000, 32'd0, 32'hFFFF_FFFF);
    apply("R7 sra pos", 2'b00, 2'b00, 0, 2'b11, 5'd3, 0, 0, 0, 0,
          32'h4000_0000, 32'd0, 32'h0800_0000);
    apply("R7 zero amt", 2'b00, 2'b00, 0, 2'b10, 5'd0, 0, 0, 0, 0,
          32'hCAFE_F00D, 32'd0, 32'hCAFE_F00D);
    // R8 set-on-less-than: signed and unsigned disagree across sign bit
    apply("R8 slt s", 2'b01, 2'b00, 0, 2'b00, 5'd0, 0, 1, 0, 0,
          32'hFFFF_FFFF, 32'd1, 32'd1);
    apply("R8 slt u", 2'b01, 2'b00, 0, 2'b00, 5'd0, 1, 1, 0, 0,
          32'hFFFF_FFFF, 32'd1, 32'd0);
    apply("R8 slt s ovf", 2'b01, 2'b00, 0, 2'b00, 5'd0, 0, 1, 0, 0,
          32'h7FFF_FFFF, 32'h8000_0000, 32'd0);
    apply("R8 slt u hi", 2'b01, 2'b00, 0, 2'b00, 5'd0, 1, 1, 0, 0,
          32'h7FFF_FFFF, 32'h8000_0000, 32'd1);
    apply("R8 slt eq", 2'b01, 2'b00, 0, 2'b00, 5'd0, 0, 1, 0, 0,
          32'd42, 32'd42, 32'd0);
    // R10 priority
    apply("R10 slt>all", 2'b00, 2'b01, 0, 2'b00, 5'd0, 0, 1, 1, 1,
          32'd1, 32'd2, 32'd1);
    apply("R10 log>arith", 2'b00, 2'b10, 0, 2'b00, 5'd0, 0, 0, 1, 1,
          32'h0000_00F0, 32'h0000_00FF, 32'h0000_000F);
    apply("R10 arith>shift", 2'b00, 2'b00, 0, 2'b10, 5'd4, 0, 0, 0, 1,
          32'h0000_0100, 32'h0000_0001, 32'h0000_0101);

    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule